// File: doc/BRIEF.md
# Key-Protected Clock Control Registers

This unit holds the clock and power control settings of a chip in a few byte-wide registers on a simple synchronous bus: an address, a write strobe, write data and combinational read data. A power control register selects the system clock divide code, turns the prescaler on or off, picks the CPU clock source and enables the high-speed and low-speed oscillators. A clock option byte carries settings that the unit passes on without decoding. A single select bit chooses the prescaler source clock. Every setting is also driven out as a level signal.

The power control register and the clock option register are guarded by a key register. Software first writes the key value 0x96 to the key address. The next write to either guarded address then takes effect, and that write also wipes the key. Every guarded write therefore needs its own unlock. A write to a guarded address while the key is wrong changes nothing and still wipes the key. It also raises a sticky violation flag, which software can read and clear.

Default map: 0x0 power control, 0x1 prescaler select, 0x2 clock option, 0x3 key, 0x4 status. Power control bits: D7–D6 divide code, D5 prescaler on, D4–D3 reserved, D2 CPU source (1 = high-speed), D1 high-speed oscillator on, D0 low-speed oscillator on.

Top module: `clk_guard_regs`

## Requirements
- R1: After reset, the outputs and read-back values are as follows. Power control reads 0x27: divide code 00, prescaler on, CPU source high-speed, both oscillators on. Prescaler select, clock option, key and status all read 0x00, and the violation output is 0.
- R2: Any byte written to the key address is stored and reads back unchanged from that address.
- R3: When the key holds 0x96, a write to power control stores D7–D6 as divide code (00 = 1/1, 01 = 1/2, 10 = 1/4, 11 = 1/8), D5 as prescaler on, D2 as CPU source (1 = high-speed), D1 as high-speed oscillator on and D0 as low-speed oscillator on. D4–D3 always read 0.
- R4: When the key holds 0x96, a write to the clock option address stores the whole byte, and the byte is visible on the read port and on the option output.
- R5: Any write to power control or clock option leaves the key at 0x00, so the next guarded write without a fresh unlock is rejected.
- R6: A write to a guarded address while the key is not 0x96 leaves that register unchanged. This includes a key of 0x95, and a key of 0x96 that was overwritten by a later key write.
- R7: A rejected guarded write sets the violation flag, seen on the violation output and as status D0. The flag stays set until a write to the status address with D0 = 1. A status write with D0 = 0 leaves it set.
- R8: The prescaler select register is not guarded. A write stores D0 (1 = low-speed source) at any time. D7–D1 read 0, and the write leaves the key unchanged.
- R9: A read of an address outside the map returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| divRatio | output | 2 | System clock divide code |
| prescEn | output | 1 | Prescaler on |
| cpuSrcHigh | output | 1 | CPU clock source: 1 high-speed, 0 low-speed |
| oscHiEn | output | 1 | High-speed oscillator on |
| oscLoEn | output | 1 | Low-speed oscillator on |
| prescSrcLow | output | 1 | Prescaler source: 1 low-speed, 0 high-speed/PLL |
| clkOption | output | 8 | Clock option byte |
| violation | output | 1 | Sticky rejected-write flag |

## Verification
The bench builds the unit with its default parameters: a 4-bit address, the five registers at 0x0 to 0x4, and key value 0x96. With those values a key one step away from the correct one (0x95) can be tried. A valid key that a second key write overwrites can also be tried, and address 0x9, outside the map, can be read. The sequence is arranged so that single-use keys, rejected writes and the sticky flag each show up as a read-back value that differs from the value a faulty unit would give.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;
  localparam int DATA_W    = 8;
  localparam int DIV_MSB   = 7;
  localparam int DIV_LSB   = 6;
  localparam int PRESC_BIT = 5;
  localparam int SRC_BIT   = 2;
  localparam int HI_BIT    = 1;
  localparam int LO_BIT    = 0;

  typedef struct packed {
    logic wrPwr;
    logic wrOpt;
    logic wrPsel;
    logic setViol;
    logic clrViol;
  } guardStrobe_t;
endpackage

// File: rtl/clk_guard_ctrl.sv
module clk_guard_ctrl
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] PSEL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h4,
  parameter logic [DATA_W-1:0] KEY_VALUE = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output guardStrobe_t      strobe,
  output logic [DATA_W-1:0] keyVal
);
  logic hitPwr, hitOpt, hitPsel, hitKey, hitStat, guardHit, unlocked;

  always_comb begin
    hitPwr   = wrEn && (addr == PWR_ADDR);
    hitOpt   = wrEn && (addr == OPT_ADDR);
    hitPsel  = wrEn && (addr == PSEL_ADDR);
    hitKey   = wrEn && (addr == KEY_ADDR);
    hitStat  = wrEn && (addr == STAT_ADDR);
    guardHit = hitPwr || hitOpt;
    unlocked = (keyVal == KEY_VALUE);

    strobe.wrPwr   = hitPwr && unlocked;
    strobe.wrOpt   = hitOpt && unlocked;
    strobe.wrPsel  = hitPsel;
    strobe.setViol = guardHit && !unlocked;
    strobe.clrViol = hitStat && wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyVal <= '0;
    end else if (hitKey) begin
      keyVal <= wdata;
    end else if (guardHit) begin
      keyVal <= '0;
    end
  end
endmodule

// File: rtl/clk_guard_dp.sv
module clk_guard_dp
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] PSEL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  guardStrobe_t      strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] keyVal,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        divRatio,
  output logic              prescEn,
  output logic              cpuSrcHigh,
  output logic              oscHiEn,
  output logic              oscLoEn,
  output logic              prescSrcLow,
  output logic [DATA_W-1:0] clkOption,
  output logic              violation
);
  logic [DATA_W-1:0] pwrRead;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divRatio   <= 2'b00;
      prescEn    <= 1'b1;
      cpuSrcHigh <= 1'b1;
      oscHiEn    <= 1'b1;
      oscLoEn    <= 1'b1;
    end else if (strobe.wrPwr) begin
      divRatio   <= wdata[DIV_MSB:DIV_LSB];
      prescEn    <= wdata[PRESC_BIT];
      cpuSrcHigh <= wdata[SRC_BIT];
      oscHiEn    <= wdata[HI_BIT];
      oscLoEn    <= wdata[LO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkOption <= '0;
    end else if (strobe.wrOpt) begin
      clkOption <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescSrcLow <= 1'b0;
    end else if (strobe.wrPsel) begin
      prescSrcLow <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      violation <= 1'b0;
    end else if (strobe.setViol) begin
      violation <= 1'b1;
    end else if (strobe.clrViol) begin
      violation <= 1'b0;
    end
  end

  always_comb begin
    pwrRead = '0;
    pwrRead[DIV_MSB:DIV_LSB] = divRatio;
    pwrRead[PRESC_BIT]       = prescEn;
    pwrRead[SRC_BIT]         = cpuSrcHigh;
    pwrRead[HI_BIT]          = oscHiEn;
    pwrRead[LO_BIT]          = oscLoEn;
  end

  always_comb begin
    unique case (addr)
      PWR_ADDR:  rdata = pwrRead;
      PSEL_ADDR: rdata = {{(DATA_W-1){1'b0}}, prescSrcLow};
      OPT_ADDR:  rdata = clkOption;
      KEY_ADDR:  rdata = keyVal;
      STAT_ADDR: rdata = {{(DATA_W-1){1'b0}}, violation};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/clk_guard_regs.sv
module clk_guard_regs
  import clk_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] PSEL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h4,
  parameter logic [7:0]        KEY_VALUE = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [1:0]        divRatio,
  output logic              prescEn,
  output logic              cpuSrcHigh,
  output logic              oscHiEn,
  output logic              oscLoEn,
  output logic              prescSrcLow,
  output logic [7:0]        clkOption,
  output logic              violation
);
  guardStrobe_t strobe;
  logic [DATA_W-1:0] keyVal;

  clk_guard_ctrl #(
    .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .PSEL_ADDR(PSEL_ADDR),
    .OPT_ADDR(OPT_ADDR), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
    .KEY_VALUE(KEY_VALUE)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .strobe(strobe), .keyVal(keyVal)
  );

  clk_guard_dp #(
    .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .PSEL_ADDR(PSEL_ADDR),
    .OPT_ADDR(OPT_ADDR), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr), .wdata(wdata),
    .keyVal(keyVal), .rdata(rdata), .divRatio(divRatio), .prescEn(prescEn),
    .cpuSrcHigh(cpuSrcHigh), .oscHiEn(oscHiEn), .oscLoEn(oscLoEn),
    .prescSrcLow(prescSrcLow), .clkOption(clkOption), .violation(violation)
  );
endmodule

// File: rtl/clk_guard_chk.sv
module clk_guard_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] PSEL_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OPT_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 'h3,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h4,
  parameter logic [7:0]        KEY_VALUE = 8'h96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        keyVal,
  input logic [1:0]        divRatio,
  input logic              prescEn,
  input logic              cpuSrcHigh,
  input logic              oscHiEn,
  input logic              oscLoEn,
  input logic              prescSrcLow,
  input logic [7:0]        clkOption,
  input logic              violation
);
  logic [5:0] pwrFields;
  assign pwrFields = {divRatio, prescEn, cpuSrcHigh, oscHiEn, oscLoEn};

  AST_KEY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && addr == KEY_ADDR |=> keyVal == $past(wdata)); // R2

  AST_KEY_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && (addr == PWR_ADDR || addr == OPT_ADDR) |=> keyVal == 8'h00); // R5

  AST_PWR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && addr == PWR_ADDR && keyVal == KEY_VALUE
    |=> pwrFields == {$past(wdata[7:5]), $past(wdata[2:0])}); // R3

  AST_OPT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && addr == OPT_ADDR && keyVal == KEY_VALUE
    |=> clkOption == $past(wdata)); // R4

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && (addr == PWR_ADDR || addr == OPT_ADDR) && keyVal != KEY_VALUE
    |=> $stable(pwrFields) && $stable(clkOption)); // R6

  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && (addr == PWR_ADDR || addr == OPT_ADDR) && keyVal != KEY_VALUE
    |=> violation); // R7

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation && !(wrEn && addr == STAT_ADDR && wdata[0]) |=> violation); // R7

  AST_PSEL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && addr == PSEL_ADDR
    |=> prescSrcLow == $past(wdata[0]) && $stable(keyVal)); // R8
endmodule

bind clk_guard_regs clk_guard_chk #(
  .ADDR_W(ADDR_W), .PWR_ADDR(PWR_ADDR), .PSEL_ADDR(PSEL_ADDR),
  .OPT_ADDR(OPT_ADDR), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
  .KEY_VALUE(KEY_VALUE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .keyVal(keyVal), .divRatio(divRatio), .prescEn(prescEn),
  .cpuSrcHigh(cpuSrcHigh), .oscHiEn(oscHiEn), .oscLoEn(oscLoEn),
  .prescSrcLow(prescSrcLow), .clkOption(clkOption), .violation(violation)
);

// File: tb/clk_guard_regs_tb_top.sv
`timescale 1ns/1ps
module clk_guard_regs_tb_top;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_PWR = 4'h0, A_PSEL = 4'h1, A_OPT = 4'h2,
                            A_KEY = 4'h3, A_STAT = 4'h4;

  logic clk = 1'b0, rst_n = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, clkOption;
  logic [1:0] divRatio;
  logic prescEn, cpuSrcHigh, oscHiEn, oscLoEn, prescSrcLow, violation;

  always #2.5 clk = ~clk;

  clk_guard_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .divRatio(divRatio), .prescEn(prescEn),
    .cpuSrcHigh(cpuSrcHigh), .oscHiEn(oscHiEn), .oscLoEn(oscLoEn),
    .prescSrcLow(prescSrcLow), .clkOption(clkOption), .violation(violation)
  );

  int compared = 0, mismatched = 0;
  bit done = 1'b0, pend = 1'b0;
  logic [7:0] expQ[$];
  int kindQ[$];
  string tagQ[$];

  // monitor: pops one expected item per request, compares away from the edge
  always @(negedge clk) begin
    if (pend) begin
      logic [7:0] exp, act;
      int kind;
      string tag;
      exp = expQ.pop_front(); kind = kindQ.pop_front(); tag = tagQ.pop_front();
      case (kind)
        0: act = rdata;
        1: act = {divRatio, prescEn, cpuSrcHigh, oscHiEn, oscLoEn, prescSrcLow, violation};
        default: act = clkOption;
      endcase
      compared++;
      if (act !== exp) begin
        mismatched++;
        $display("FAIL %s kind%0d actual=%02h expected=%02h", tag, kind, act, exp);
      end
      pend = 1'b0;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wdata = d;
  endtask

  task automatic expect_item(input int kind, input logic [AW-1:0] a,
                             input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    wrEn = 1'b0; addr = a;
    expQ.push_back(e); kindQ.push_back(kind); tagQ.push_back(tag);
    pend = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    expect_item(0, a, e, tag);
  endtask

  // output vector: {divRatio[1:0], prescEn, cpuSrcHigh, oscHiEn, oscLoEn, prescSrcLow, violation}
  task automatic outs(input logic [7:0] e, input string tag);
    expect_item(1, A_PWR, e, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(A_PWR, 8'h27, "R1 power reset");
    rd(A_KEY, 8'h00, "R1 key reset");
    rd(A_OPT, 8'h00, "R1 option reset");
    rd(A_PSEL, 8'h00, "R1 select reset");
    rd(A_STAT, 8'h00, "R1 status reset");
    outs(8'h3C, "R1 outputs reset");
    // locked write
    wr(A_PWR, 8'h00);
    rd(A_PWR, 8'h27, "R6 locked power write");
    outs(8'h3D, "R7 violation output");
    rd(A_STAT, 8'h01, "R7 status set");
    wr(A_STAT, 8'h00);
    rd(A_STAT, 8'h01, "R7 sticky on zero write");
    wr(A_STAT, 8'h01);
    rd(A_STAT, 8'h00, "R7 cleared");
    // near-miss key
    wr(A_KEY, 8'h95);
    rd(A_KEY, 8'h95, "R2 key readback");
    wr(A_PWR, 8'hFF);
    rd(A_PWR, 8'h27, "R6 near-miss key");
    rd(A_KEY, 8'h00, "R5 key wiped by locked write");
    wr(A_STAT, 8'h01);
    // unlocked power write
    wr(A_KEY, 8'h96);
    wr(A_PWR, 8'hDA);
    rd(A_PWR, 8'hC2, "R3 power fields reserved zero");
    outs(8'hC8, "R3 power outputs");
    rd(A_KEY, 8'h00, "R5 key spent");
    wr(A_PWR, 8'h27);
    rd(A_PWR, 8'hC2, "R5 second write rejected");
    wr(A_STAT, 8'h01);
    wr(A_KEY, 8'h96);
    wr(A_PWR, 8'h61);
    outs(8'h64, "R3 divide 1/2 low osc");
    // option register
    wr(A_KEY, 8'h96);
    wr(A_OPT, 8'hA5);
    rd(A_OPT, 8'hA5, "R4 option readback");
    expect_item(2, A_OPT, 8'hA5, "R4 option output");
    wr(A_OPT, 8'h3C);
    rd(A_OPT, 8'hA5, "R6 option locked");
    // unguarded select keeps key
    wr(A_KEY, 8'h96);
    wr(A_PSEL, 8'hFF);
    rd(A_PSEL, 8'h01, "R8 select stored");
    rd(A_KEY, 8'h96, "R8 key kept");
    wr(A_OPT, 8'h11);
    rd(A_OPT, 8'h11, "R4 option after select");
    wr(A_PSEL, 8'h00);
    rd(A_PSEL, 8'h00, "R8 select cleared");
    // overwritten key
    wr(A_KEY, 8'h96);
    wr(A_KEY, 8'h00);
    wr(A_PWR, 8'h00);
    rd(A_PWR, 8'h61, "R6 overwritten key");
    rd(4'h9, 8'h00, "R9 unmapped read");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule